// File: doc/BRIEF.md
# Processor-Port Memory Bank Decoder

This block sits between an 8-bit CPU's 16-bit address bus and the rest of the system. It takes each address and turns it into exactly one target select: main RAM, one of three ROMs, one of the on-board I/O devices, or the two-register processor port itself. The mapping is controlled by a 3-bit bank value. That value is built from two registers the block holds at addresses 0 and 1. One is a direction register and the other is a data register. The bank value is the inverted direction register ORed with the data register, so any line not driven as an output reads as 1.

For each access the block gives a one-hot target select and a local register offset for the selected target. It also gives two write strobes: one for RAM and one for the selected device. Writes into a ROM window always land in the RAM underneath. The block also holds the nibble-wide colour RAM. A read from it returns the stored nibble in the low half and a free-running pseudo-random pattern in the high half.

Decode is combinational from the address and the registered bank value. A write to the port registers takes effect on the clock edge, so the new mapping applies from the next access onward.

Top module: `bank_decoder`

## Requirements
- R1: After synchronous reset both port registers read 0, so the bank value is 3'b111 and BASIC ROM, system ROM and I/O are all mapped.
- R2: The bank value equals bits 2:0 of (~direction | data).
- R3: $A000–$BFFF selects the 8 KB interpreter ROM (select bit 1) only when bank[1:0] = 2'b11, with offset = address[12:0]. Otherwise it selects RAM (bit 0).
- R4: $E000–$FFFF selects the system ROM (bit 3) whenever bank[1] = 1, with offset = address[12:0]. Otherwise it selects RAM.
- R5: If bank[1:0] = 0, $D000–$DFFF is RAM. Otherwise it is the character ROM (bit 2, offset = address[11:0]) when bank[2] = 0, and the I/O window when bank[2] = 1.
- R6: Inside the I/O window, address[11:8] picks the target:
  - 0–3 selects video (bit 4, offset = address[5:0]).
  - 4–7 selects sound (bit 5, offset = address[4:0]).
  - 8–B selects colour RAM (bit 6, offset = address[9:0]).
  - C selects timer 1 (bit 7, offset = address[3:0]).
  - D selects timer 2 (bit 8, offset = address[3:0]).
- R7: In the I/O window, $DF00–$DF0F selects the expansion unit (bit 9, offset = address[3:0]). Every other address with address[11:8] of E or F selects the open area (bit 10), which receives no write strobe.
- R8: A colour RAM write keeps only wdata[3:0]. A later read returns that nibble on colour_rdata[3:0].
- R9: On a write, ram_we is asserted for targets RAM, either ROM window, character ROM and port. dev_we is asserted only for targets video, sound, colour, timer 1, timer 2 and expansion unit. The two strobes are never high together.
- R10: Addresses 0 and 1 select the port (bit 11). A write there updates the direction register (address 0) or the data register (address 1), and also raises ram_we. port_rdata returns the addressed register. The new bank value applies from the next cycle.
- R11: Addresses $0002–$9FFF and $C000–$CFFF always select RAM, with offset 0. RAM, port and open-area selects all carry offset 0.
- R12: Exactly one select bit is set in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write cycle when high, read otherwise |
| tgt_sel | output | 12 | One-hot target select (bit positions per R3–R11) |
| tgt_off | output | 13 | Local offset into the selected target |
| ram_we | output | 1 | Write strobe for main RAM |
| dev_we | output | 1 | Write strobe for the selected device |
| port_rdata | output | 8 | Read data of the addressed port register |
| colour_rdata | output | 8 | Colour RAM read data; low nibble stored, high nibble pseudo-random |

## Verification
If a port register holds the wrong value, the error shows within one access to a banked window. Reading $A000, $D000 or $E000 gives the wrong select, and an address-1 readback differs on the next cycle. A wrong colour nibble only appears when that cell is read back, so the bench writes a spread of cells and reads each one again. The reference model tracks both registers and every colour cell written. All eight bank values, plus a mixed direction/data pattern, are swept across every region boundary, so a decode slip shows up in the select, the offset or a strobe in the same cycle.

// File: rtl/bank_pkg.sv
// Package: shared constants for the processor-port bank decoder.
// Assumes a 16-bit address bus and an 8-bit data bus.
package bank_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int OFF_W    = 13;
    localparam int BANK_W   = 3;
    localparam int NTGT     = 12;
    localparam int NIB_W    = 4;
    localparam int COL_AW   = 10;

    // select bit positions
    localparam int T_RAM    = 0;
    localparam int T_BASIC  = 1;
    localparam int T_CHAR   = 2;
    localparam int T_SYSROM = 3;
    localparam int T_VIDEO  = 4;
    localparam int T_SOUND  = 5;
    localparam int T_COLOUR = 6;
    localparam int T_TMR1   = 7;
    localparam int T_TMR2   = 8;
    localparam int T_EXPU   = 9;
    localparam int T_OPEN   = 10;
    localparam int T_PORT   = 11;

    typedef logic [NTGT-1:0] tsel_t;

    localparam tsel_t RAM_WR_MASK = tsel_t'((1 << T_RAM) | (1 << T_BASIC) |
                                            (1 << T_CHAR) | (1 << T_SYSROM) |
                                            (1 << T_PORT));
    localparam tsel_t DEV_WR_MASK = tsel_t'((1 << T_VIDEO) | (1 << T_SOUND) |
                                            (1 << T_COLOUR) | (1 << T_TMR1) |
                                            (1 << T_TMR2) | (1 << T_EXPU));
endpackage

// File: rtl/bank_port_regs.sv
// Module: holds the direction and data registers of the processor port.
// Derives the bank value from them. Assumes the write strobe is already
// qualified with address 0/1; sel_data picks the data register.
module bank_port_regs #(
    parameter int DW = 8,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          sel_data,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] dir_q,
    output logic [DW-1:0] dat_q,
    output logic [BW-1:0] bank
);
    // Register update: clear on reset, load the addressed register on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            dat_q <= '0;
        end else if (wr_en) begin
            if (sel_data) dat_q <= wdata;
            else          dir_q <= wdata;
        end
    end

    // Bank value: lines not driven as outputs read as 1.
    always_comb begin
        bank = ~dir_q[BW-1:0] | dat_q[BW-1:0];
    end
endmodule

// File: rtl/bank_region_decode.sv
// Module: combinational address decode into a one-hot target and local offset.
// Assumes bank[0..2] carry the two ROM-enable bits and the char/IO choice.
module bank_region_decode
    import bank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    output tsel_t             sel,
    output logic [OFF_W-1:0]  off
);
    localparam int HI_LSB = ADDR_W - 4;

    logic [3:0] top_nib;
    logic [3:0] io_nib;
    logic       port_hit;
    logic       rom_pair;
    logic       d_mapped;

    // Field extraction: nibble of the 4 KB region and of the 256-byte I/O slot.
    always_comb begin
        top_nib  = addr[ADDR_W-1:HI_LSB];
        io_nib   = addr[11:8];
        port_hit = (addr[ADDR_W-1:1] == '0);
        rom_pair = (bank[1:0] == 2'b11);
        d_mapped = (bank[1:0] != 2'b00);
    end

    // Target choice: one select bit and its offset for every address.
    always_comb begin
        sel = '0;
        off = '0;
        if (port_hit) begin
            sel[T_PORT] = 1'b1;
        end else begin
            unique case (top_nib)
                4'hA, 4'hB: begin
                    if (rom_pair) begin
                        sel[T_BASIC] = 1'b1;
                        off          = addr[OFF_W-1:0];
                    end else begin
                        sel[T_RAM] = 1'b1;
                    end
                end
                4'hD: begin
                    if (!d_mapped) begin
                        sel[T_RAM] = 1'b1;
                    end else if (!bank[2]) begin
                        sel[T_CHAR] = 1'b1;
                        off         = {1'b0, addr[11:0]};
                    end else begin
                        unique case (io_nib)
                            4'h0, 4'h1, 4'h2, 4'h3: begin
                                sel[T_VIDEO] = 1'b1;
                                off          = {{(OFF_W-6){1'b0}}, addr[5:0]};
                            end
                            4'h4, 4'h5, 4'h6, 4'h7: begin
                                sel[T_SOUND] = 1'b1;
                                off          = {{(OFF_W-5){1'b0}}, addr[4:0]};
                            end
                            4'h8, 4'h9, 4'hA, 4'hB: begin
                                sel[T_COLOUR] = 1'b1;
                                off           = {{(OFF_W-COL_AW){1'b0}}, addr[COL_AW-1:0]};
                            end
                            4'hC: begin
                                sel[T_TMR1] = 1'b1;
                                off         = {{(OFF_W-4){1'b0}}, addr[3:0]};
                            end
                            4'hD: begin
                                sel[T_TMR2] = 1'b1;
                                off         = {{(OFF_W-4){1'b0}}, addr[3:0]};
                            end
                            default: begin
                                if (addr[11:4] == 8'hF0) begin
                                    sel[T_EXPU] = 1'b1;
                                    off         = {{(OFF_W-4){1'b0}}, addr[3:0]};
                                end else begin
                                    sel[T_OPEN] = 1'b1;
                                end
                            end
                        endcase
                    end
                end
                4'hE, 4'hF: begin
                    if (bank[1]) begin
                        sel[T_SYSROM] = 1'b1;
                        off           = addr[OFF_W-1:0];
                    end else begin
                        sel[T_RAM] = 1'b1;
                    end
                end
                default: sel[T_RAM] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/bank_colour_ram.sv
// Module: nibble-wide colour RAM with a pseudo-random upper read nibble.
// Assumes a write strobe already qualified by the colour select.
// Storage is not reset; the noise generator is.
module bank_colour_ram #(
    parameter int AW    = 10,
    parameter int NW    = 4,
    parameter int DW    = 8,
    parameter int LFSR_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [NW-1:0] wnib,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int NOISE_W = DW - NW;

    logic [NW-1:0]     mem [DEPTH];
    logic [LFSR_W-1:0] lfsr;
    logic              fb;

    // Cell write: only the low nibble is kept.
    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wnib;
    end

    // Feedback taps of the noise generator (x^8+x^6+x^5+x^4+1).
    always_comb begin
        fb = lfsr[LFSR_W-1] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3];
    end

    // Noise generator: advances every cycle, seeded on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr <= {{(LFSR_W-1){1'b0}}, 1'b1};
        else        lfsr <= {lfsr[LFSR_W-2:0], fb};
    end

    // Read path: stored nibble below, noise above.
    always_comb begin
        rdata = {lfsr[NOISE_W-1:0], mem[addr]};
    end
endmodule

// File: rtl/bank_decoder.sv
// Module: top of the processor-port memory bank decoder.
// Assumes one access per cycle; decode is combinational from the address and
// the registered bank value, so a port write changes the map from the next cycle.
module bank_decoder
    import bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    output logic [11:0]       tgt_sel,
    output logic [12:0]       tgt_off,
    output logic              ram_we,
    output logic              dev_we,
    output logic [7:0]        port_rdata,
    output logic [7:0]        colour_rdata
);
    logic [DATA_W-1:0] dir_q;
    logic [DATA_W-1:0] dat_q;
    logic [BANK_W-1:0] bank;
    logic              port_wr;
    logic              colour_wr;
    tsel_t             sel;
    logic [OFF_W-1:0]  off;

    // Port write strobe: write cycle at address 0 or 1.
    always_comb begin
        port_wr = cpu_we && (cpu_addr[ADDR_W-1:1] == '0);
    end

    bank_port_regs #(.DW(DATA_W), .BW(BANK_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (port_wr),
        .sel_data (cpu_addr[0]),
        .wdata    (cpu_wdata),
        .dir_q    (dir_q),
        .dat_q    (dat_q),
        .bank     (bank)
    );

    bank_region_decode i_dec (
        .addr (cpu_addr),
        .bank (bank),
        .sel  (sel),
        .off  (off)
    );

    // Colour write strobe: device write that targets the colour RAM.
    always_comb begin
        colour_wr = cpu_we && sel[T_COLOUR];
    end

    bank_colour_ram #(.AW(COL_AW), .NW(NIB_W), .DW(DATA_W)) i_col (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (colour_wr),
        .addr  (cpu_addr[COL_AW-1:0]),
        .wnib  (cpu_wdata[NIB_W-1:0]),
        .rdata (colour_rdata)
    );

    // Output drive: selects, strobes and the addressed port register.
    always_comb begin
        tgt_sel    = sel;
        tgt_off    = off;
        ram_we     = cpu_we && |(sel & RAM_WR_MASK);
        dev_we     = cpu_we && |(sel & DEV_WR_MASK);
        port_rdata = cpu_addr[0] ? dat_q : dir_q;
    end
endmodule

// File: rtl/bank_decoder_chk.sv
// Module: property checker for bank_decoder, attached by bind.
module bank_decoder_chk
    import bank_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_we,
    input logic [11:0] tgt_sel,
    input logic        ram_we,
    input logic        dev_we,
    input logic [7:0]  port_rdata
);
    a_r12_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tgt_sel) == 1);

    a_r11_low_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= 16'h0002 && cpu_addr < 16'hA000) |-> tgt_sel[T_RAM]);

    a_r9_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && dev_we));

    a_r9_dev_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> (cpu_we && cpu_addr[15:12] == 4'hD));

    a_r4_sysrom_range: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel[T_SYSROM] |-> (cpu_addr[15:13] == 3'b111));

    a_r7_unit_range: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sel[T_EXPU] |-> (cpu_addr[15:4] == 12'hDF0));

    a_r10_port_update: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == 16'h0001) |=>
            (cpu_addr != 16'h0001 || port_rdata == $past(cpu_wdata)));
endmodule

bind bank_decoder bank_decoder_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_we     (cpu_we),
    .tgt_sel    (tgt_sel),
    .ram_we     (ram_we),
    .dev_we     (dev_we),
    .port_rdata (port_rdata)
);

// File: tb/test_bank_decoder.sv
`timescale 1ns/1ps
module test_bank_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [11:0] tgt_sel;
    logic [12:0] tgt_off;
    logic        ram_we;
    logic        dev_we;
    logic [7:0]  port_rdata;
    logic [7:0]  colour_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    int m_dir = 0;
    int m_dat = 0;
    int m_col [1024];
    bit m_colv [1024];

    always #2.5 clk = ~clk;

    bank_decoder i_bank_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .tgt_sel(tgt_sel), .tgt_off(tgt_off), .ram_we(ram_we),
        .dev_we(dev_we), .port_rdata(port_rdata), .colour_rdata(colour_rdata)
    );

    function automatic int exp_idx(int a, int b);
        int n;
        if (a < 2) return 11;
        if (a < 'hA000) return 0;
        if (a < 'hC000) return ((b & 3) == 3) ? 1 : 0;
        if (a < 'hD000) return 0;
        if (a < 'hE000) begin
            if ((b & 3) == 0) return 0;
            if ((b & 4) == 0) return 2;
            n = (a >> 8) & 15;
            if (n < 4)  return 4;
            if (n < 8)  return 5;
            if (n < 12) return 6;
            if (n == 12) return 7;
            if (n == 13) return 8;
            if (a >= 'hDF00 && a <= 'hDF0F) return 9;
            return 10;
        end
        return ((b & 2) != 0) ? 3 : 0;
    endfunction

    function automatic int exp_off(int a, int idx);
        case (idx)
            1, 3:    return a & 'h1FFF;
            2:       return a & 'hFFF;
            4:       return a & 'h3F;
            5:       return a & 'h1F;
            6:       return a & 'h3FF;
            7, 8, 9: return a & 'hF;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(int idx);
        case (idx)
            0:       return "R11";
            1:       return "R3";
            2:       return "R5";
            3:       return "R4";
            9, 10:   return "R7";
            11:      return "R10";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One access: drive at the falling edge, compare, then advance the model.
    task automatic step(input int a, input int d, input bit w, input string tag);
        int b, idx, eoff;
        bit eram, edev;
        string r;
        @(negedge clk);
        cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_we = w;
        #1;
        b    = ((~m_dir) | m_dat) & 7;                 // R2
        idx  = exp_idx(a, b);
        eoff = exp_off(a, idx);
        r    = (tag != "") ? tag : req_of(idx);
        eram = w && (idx == 0 || idx == 1 || idx == 2 || idx == 3 || idx == 11);
        edev = w && (idx >= 4 && idx <= 9);
        check(tgt_sel == 12'(1 << idx), r, "select", int'(tgt_sel), 1 << idx);   // R12
        check(int'(tgt_off) == eoff, r, "offset", int'(tgt_off), eoff);
        check(ram_we == eram && dev_we == edev, {r, " R9"}, "strobes",
              int'({ram_we, dev_we}), int'({eram, edev}));
        if (idx == 11) begin
            int ep;
            ep = (a == 1) ? m_dat : m_dir;
            check(int'(port_rdata) == ep, {r, " R10"}, "port read", int'(port_rdata), ep);
        end
        if (idx == 6 && !w && m_colv[a & 'h3FF]) begin
            int ec;
            ec = m_col[a & 'h3FF];
            check(int'(colour_rdata[3:0]) == ec, "R8", "colour nibble",
                  int'(colour_rdata[3:0]), ec);
        end
        if (w && a == 0) m_dir = d & 'hFF;
        if (w && a == 1) m_dat = d & 'hFF;
        if (w && idx == 6) begin
            m_col[a & 'h3FF]  = d & 'hF;
            m_colv[a & 'h3FF] = 1'b1;
        end
    endtask

    task automatic sweep(input bit with_writes);
        int alist [23] = '{'h0000, 'h0001, 'h0002, 'h1234, 'h9FFF, 'hA000, 'hBFFF,
                           'hC000, 'hCFFF, 'hD000, 'hD03F, 'hD41F, 'hD800, 'hDBFF,
                           'hDC0F, 'hDD05, 'hDE00, 'hDF00, 'hDF0F, 'hDF10, 'hDFFF,
                           'hE000, 'hFFFF};
        foreach (alist[i]) begin
            step(alist[i], 0, 1'b0, "");
            if (with_writes && alist[i] >= 2)
                step(alist[i], (alist[i] ^ 'hA5) & 'hFF, 1'b1, "");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state, everything mapped
        step('h0000, 0, 1'b0, "R1");
        step('h0001, 0, 1'b0, "R1");
        step('hA000, 0, 1'b0, "R1");
        step('hD000, 0, 1'b0, "R1");
        step('hE000, 0, 1'b0, "R1");
        // R2: direction 0 keeps all bits high regardless of data
        step('h0001, 'h00, 1'b1, "R10");
        step('hA123, 0, 1'b0, "R2");
        step('hE456, 0, 1'b0, "R2");
        // R10: new map applies from the very next access
        step('h0000, 'hFF, 1'b1, "R10");
        step('hE000, 0, 1'b0, "R10");
        step('h0000, 0, 1'b0, "R10");
        // all bank values across every region
        for (int k = 0; k < 8; k++) begin
            step('h0001, k, 1'b1, "R10");
            sweep(k[0]);
        end
        // R2: mixed direction/data -> bank 3'b010
        step('h0000, 'h05, 1'b1, "R2");
        step('h0001, 'h02, 1'b1, "R2");
        sweep(1'b1);
        // R8: colour RAM nibble storage with I/O mapped
        step('h0000, 'hFF, 1'b1, "R8");
        step('h0001, 'h07, 1'b1, "R8");
        for (int i = 0; i < 16; i++) step('hD800 + i * 37, (i * 'h13) ^ 'hF0, 1'b1, "R8");
        step('hDBFF, 'hC9, 1'b1, "R8");
        for (int i = 0; i < 16; i++) step('hD800 + i * 37, 0, 1'b0, "R8");
        step('hDBFF, 0, 1'b0, "R8");
        // R9: with I/O out, a D-range write goes to RAM, not the device
        step('h0001, 'h00, 1'b1, "R9");
        step('hD800, 'h0E, 1'b1, "R9");
        step('h0001, 'h07, 1'b1, "R9");
        step('hD800, 0, 1'b0, "R8");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule